// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a synthesizable, single-clock static RAM with a pipelined read path and byte-granular writes. All inputs are sampled on the rising clock edge: the address, the write data, the chip selects and the write controls. Each cycle is a read, a write or idle. A selected cycle is a write when the global write is active, or when the byte-write enable is active together with at least one byte strobe. Every other selected cycle is a read. A write is committed to the array on the edge after the one that captured it, with no further action from the driver. Read data passes through an output register before it reaches the data port.

The shared data bus is split into `din`, `dout` and a drive enable `dout_en`. The data stays driven for one extra cycle after the last read. This is the double-cycle deselect behaviour, and it lets a controller turn the bus around without a gap. A snooze input freezes the block into a low-activity standby state. While it is active, the block accepts no new commands, does not drive the bus, and keeps its contents. Burst address generation is left to a separate block. The block takes one address per command.

Top module: `sram_pipe_bw`

## Requirements
- R1: A read command sampled at edge k places the addressed word on `dout` after edge k+1, with `dout_en` high when `oe_n` is low. Back-to-back reads stream one word per cycle.
- R2: With `gw_n` low, a selected cycle writes all bytes of the word, whatever the values of `bwe_n` and `bw_n`.
- R3: With `gw_n` high and `bwe_n` low, byte i is written only when `bw_n[i]` is low. `bw_n[i]` controls `din[8i+7:8i]`. Any subset of the byte lanes may be written, and the other lanes keep their old value.
- R4: A selected cycle with `gw_n` high and no write term active is a read. This covers `bwe_n` high, and it covers all `bw_n` bits high. Such a cycle changes no stored byte.
- R5: A read of an address that was written in the cycle just before returns the newly written data.
- R6: With `THREE_SEL`=1, a cycle is selected only when `ce_n`=0, `ce2`=1 and `ce2_n`=0. With `THREE_SEL`=0, `ce2_n` is ignored. A deselected cycle neither writes nor starts a bus drive.
- R7: After the data cycle of the last read, `dout_en` stays high for exactly one further cycle with `dout` unchanged, and then goes low.
- R8: `oe_n` gates `dout_en` in the same cycle, without any register stage in between.
- R9: While `sleep` is high, commands are ignored, `dout_en` is low and the stored contents are kept. The first edge after `sleep` falls accepts a command.
- R10: After reset, `dout_en` is low and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset of the pipeline registers, active low |
| sleep | input | 1 | Snooze request, active high |
| ce_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce2_n | input | 1 | Third chip select, active low, used only when THREE_SEL=1 |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NB | Per-byte write strobes, active low |
| addr | input | AW | Word address |
| din | input | 8*NB | Write data |
| oe_n | input | 1 | Output enable, active low, not registered |
| dout | output | 8*NB | Read data from the output register |
| dout_en | output | 1 | Bus drive enable for dout |

## Verification
The case the bench targets is a write commit and a read capture landing on the same edge at the same address. This happens when a write is followed at once by a read of that word. The result is judged by whether the word comes back with the new lanes merged into the old ones. The bench also overlaps the extra cycle of double-cycle deselect with a change of `oe_n` and with `sleep`. In those overlaps `dout_en` must follow the gates in the same cycle, while `dout` keeps the previously read word.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_t;
endpackage

// File: rtl/sram_select.sv
module sram_select #(
    parameter bit THREE_SEL = 1'b1
) (
    input  logic ce_n,
    input  logic ce2,
    input  logic ce2_n,
    output logic sel
);
    generate
        if (THREE_SEL) begin : g_three
            assign sel = !ce_n && ce2 && !ce2_n;
        end else begin : g_two
            logic unused_ce2_n;
            assign unused_ce2_n = ce2_n;
            assign sel = !ce_n && ce2;
        end
    endgenerate
endmodule

// File: rtl/sram_wmask.sv
module sram_wmask #(
    parameter int NB = 4
) (
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    output logic [NB-1:0] mask,
    output logic          is_wr
);
    always_comb begin
        if (!gw_n) begin
            mask = '1;
        end else if (!bwe_n) begin
            mask = ~bw_n;
        end else begin
            mask = '0;
        end
        is_wr = |mask;
    end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int AW = 6,
    parameter int NB = 4,
    localparam int LW    = sram_pkg::LANE_W,
    localparam int DW    = NB * LW,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [NB-1:0] wmask,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    generate
        for (genvar b = 0; b < NB; b++) begin : g_lane
            logic [LW-1:0] lane_mem [DEPTH];

            always_ff @(posedge clk) begin
                if (we && wmask[b]) begin
                    lane_mem[waddr] <= wdata[b*LW +: LW];
                end
            end

            assign rdata[b*LW +: LW] = lane_mem[raddr];
        end
    endgenerate
endmodule

// File: rtl/sram_pipe_bw.sv
module sram_pipe_bw #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter bit THREE_SEL = 1'b1,
    localparam int DW = NB * sram_pkg::LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          ce_n,
    input  logic          ce2,
    input  logic          ce2_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          oe_n,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    import sram_pkg::*;

    typedef struct packed {
        cyc_t          s1_kind;
        logic [AW-1:0] s1_addr;
        logic [DW-1:0] s1_data;
        logic [NB-1:0] s1_mask;
        logic          rd2;
        logic          rd3;
        logic [DW-1:0] out_data;
    } state_t;

    state_t q, d;

    logic          sel;
    logic          is_wr;
    logic [NB-1:0] mask;
    logic [DW-1:0] rdata;
    logic          mem_we;

    sram_select #(.THREE_SEL(THREE_SEL)) u_sel (
        .ce_n  (ce_n),
        .ce2   (ce2),
        .ce2_n (ce2_n),
        .sel   (sel)
    );

    sram_wmask #(.NB(NB)) u_mask (
        .gw_n  (gw_n),
        .bwe_n (bwe_n),
        .bw_n  (bw_n),
        .mask  (mask),
        .is_wr (is_wr)
    );

    assign mem_we = (q.s1_kind == CYC_WRITE);

    sram_array #(.AW(AW), .NB(NB)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .wmask (q.s1_mask),
        .waddr (q.s1_addr),
        .wdata (q.s1_data),
        .raddr (q.s1_addr),
        .rdata (rdata)
    );

    always_comb begin
        d = q;
        if (sel && !sleep) begin
            d.s1_kind = is_wr ? CYC_WRITE : CYC_READ;
        end else begin
            d.s1_kind = CYC_IDLE;
        end
        d.s1_addr = addr;
        d.s1_data = din;
        d.s1_mask = mask;
        if (q.s1_kind == CYC_READ) begin
            d.out_data = rdata;
        end
        d.rd2 = (q.s1_kind == CYC_READ);
        d.rd3 = q.rd2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout    = q.out_data;
    assign dout_en = !oe_n && !sleep && (q.rd2 || q.rd3);

    AST_SLEEP_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (q.s1_kind == CYC_IDLE)); // R9
    AST_DESELECT_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (q.s1_kind == CYC_IDLE)); // R6
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !sleep && !is_wr) |-> ##2 q.rd2); // R1
    AST_DCD_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !sleep && !is_wr) |-> ##3 q.rd3); // R7
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1_kind != CYC_READ) |=> $stable(q.out_data)); // R7
endmodule

// File: tb/sim_sram_pipe_bw.sv
module sim_sram_pipe_bw;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep = 1'b0;
    logic          ce_n = 1'b1, ce2 = 1'b1, ce2_n = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [NB-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dout, dout1;
    logic          dout_en, dout_en1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [DW-1:0] model [64];

    always #2 clk = ~clk;

    sram_pipe_bw #(.AW(AW), .NB(NB), .THREE_SEL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce_n(ce_n), .ce2(ce2),
        .ce2_n(ce2_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr),
        .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
    );

    sram_pipe_bw #(.AW(AW), .NB(NB), .THREE_SEL(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce_n(ce_n), .ce2(ce2),
        .ce2_n(ce2_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr),
        .din(din), .oe_n(oe_n), .dout(dout1), .dout_en(dout_en1)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // set inputs at a falling edge, then return at the next falling edge
    task automatic cyc(input logic c_n, input logic c2, input logic c2_n, input logic slp,
                       input logic g, input logic be, input logic [NB-1:0] b,
                       input logic [AW-1:0] a, input logic [DW-1:0] dat);
        ce_n = c_n; ce2 = c2; ce2_n = c2_n; sleep = slp;
        gw_n = g; bwe_n = be; bw_n = b; addr = a; din = dat;
        @(negedge clk);
    endtask

    function automatic void apply(input logic [AW-1:0] a, input logic [DW-1:0] dat,
                                  input logic g, input logic be, input logic [NB-1:0] b);
        for (int i = 0; i < NB; i++) begin
            if (!g || (!be && !b[i])) model[a][i*8 +: 8] = dat[i*8 +: 8];
        end
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] dat,
                      input logic g, input logic be, input logic [NB-1:0] b);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, g, be, b, a, dat);
        apply(a, dat, g, be, b);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '1, a, '0);
    endtask

    task automatic idle();
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '1, '0, '0);
    endtask

    task automatic read_chk(input string tag, input logic [AW-1:0] a);
        rd(a);
        idle();
        chk({tag, " drive"}, {31'd0, dout_en}, 32'd1);
        chk({tag, " data"}, dout, model[a]);
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return {8'(a), 8'(~a), 8'(a * 3 + 1), 8'hA5 ^ 8'(a)};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset drive", {31'd0, dout_en}, 32'd0);
        chk("R10 reset data", dout, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: global write overrides whatever the byte controls say
        for (int a = 0; a < 64; a++) wr(AW'(a), pat(a), 1'b0, a[4], NB'(a));
        idle();
        for (int a = 0; a < 64; a++) read_chk("R2 global write", AW'(a));

        // R3/R4: every strobe pattern with byte-write enable active
        for (int a = 0; a < 16; a++) wr(AW'(a), 32'h1111_1111 * (a + 1), 1'b1, 1'b0, NB'(a));
        idle();
        for (int a = 0; a < 16; a++) read_chk("R3 byte lanes", AW'(a));
        read_chk("R4 all strobes high keeps word", AW'(15));

        // R4: byte-write enable high, strobes active -> read, no change
        for (int a = 16; a < 20; a++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '0, AW'(a), 32'hDEAD_BEEF);
        idle();
        for (int a = 16; a < 20; a++) read_chk("R4 no write term", AW'(a));

        // R5: write then read of the same word in the next cycle
        for (int a = 40; a < 44; a++) begin
            wr(AW'(a), 32'hC0DE_0000 + a, 1'b1, 1'b0, 4'b0101);
            read_chk("R5 read after write", AW'(a));
        end

        // R1: streamed reads, one word per cycle
        idle(); idle(); idle();
        for (int i = 0; i < 9; i++) begin
            if (i < 8) rd(AW'(i + 8)); else idle();
            if (i >= 1) begin
                chk("R1 stream drive", {31'd0, dout_en}, 32'd1);
                chk("R1 stream data", dout, model[i + 7]);
            end
        end

        // R7: double-cycle deselect
        idle(); idle(); idle();
        rd(AW'(33));
        idle();
        chk("R7 first data cycle", dout, model[33]);
        idle();
        chk("R7 extra cycle drive", {31'd0, dout_en}, 32'd1);
        chk("R7 extra cycle data", dout, model[33]);
        idle();
        chk("R7 released", {31'd0, dout_en}, 32'd0);

        // R8: output enable acts in the same cycle
        rd(AW'(34));
        idle();
        oe_n = 1'b1; #1;
        chk("R8 oe_n high", {31'd0, dout_en}, 32'd0);
        oe_n = 1'b0; #1;
        chk("R8 oe_n low", {31'd0, dout_en}, 32'd1);
        idle(); idle();

        // R6: each select term deselects u0; u1 ignores ce2_n
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '1, AW'(20), 32'h1234_5678);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '1, AW'(21), 32'h1234_5678);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, AW'(22), 32'h9ABC_DEF0);
        idle();
        chk("R6 deselected no drive", {31'd0, dout_en}, 32'd0);
        read_chk("R6 ce_n high", AW'(20));
        read_chk("R6 ce2 low", AW'(21));
        read_chk("R6 ce2_n high", AW'(22));
        chk("R6 two-select variant wrote", dout1, 32'h9ABC_DEF0);
        idle(); idle();
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, AW'(23), '0);
        idle();
        chk("R6 deselected read no drive", {31'd0, dout_en}, 32'd0);
        chk("R6 two-select variant reads", {31'd0, dout_en1}, 32'd1);

        // R9: snooze
        idle(); idle();
        wr(AW'(30), 32'h5A5A_0F0F, 1'b0, 1'b1, '1);
        rd(AW'(31));
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, AW'(30), 32'hFFFF_FFFF);
        chk("R9 no drive in snooze", {31'd0, dout_en}, 32'd0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '1, AW'(30), '0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '1, AW'(30), '0);
        chk("R9 snoozed read no drive", {31'd0, dout_en}, 32'd0);
        read_chk("R9 contents kept, first edge accepts", AW'(30));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule